// File: doc/BRIEF.md
# Idle-State Coordination Resolver

This block gathers the idle-state requests of every hardware thread in a small multi-core cluster. It reduces them to one resolved state per core and then to one state for the whole package. The states are ordered by depth: active, light halt, extended halt, clock-stopped and power-gated. Because the codes follow that order, resolving a set of requests means taking the smallest code in the set. A core is only as deep as its least idle thread, and the package is only as deep as its least idle core.

An enable input turns on promotion of light halt to extended halt. Promotion is granted only when no core is active. When the package settles in extended halt, the block raises a minimum-frequency request and then, one cycle later, a voltage-reduction request. An interrupt wakes a core at once. An access to a monitored address also wakes a core, but only if that core went idle through a monitor/wait entry.

Top module: `idle_resolver`

## Requirements
- R1: State codes are 3 bits: 0 active, 1 light halt, 2 extended halt, 3 clock-stopped, 4 power-gated. Thread t of core c is at `thrReq[3*(2c+t) +: 3]` and core c is at `coreState[3c +: 3]`. A request code above 4 is treated as 4.
- R2: A core resolves to the smallest code requested by its threads, so one active thread keeps the core active.
- R3: The package resolves to the smallest of the reported core states, so one active core keeps the package active.
- R4: With `promoteEn` low, an extended-halt request counts as light halt, and neither a core nor the package reports code 2.
- R5: With `promoteEn` high, a core or package result of light halt or extended halt is reported as extended halt (2) when every core is non-active, and as light halt (1) otherwise.
- R6: `coreState` and `pkgState` are registered. They take the value for the current inputs at the next rising clock edge and do not change before it.
- R7: When `irq[c]` is high at a clock edge, core c becomes active at that edge whatever its threads request. It returns to its requested state at the first edge where `irq[c]` is low.
- R8: `monHit[c]` wakes core c like an interrupt only if `mwaitReq[c]` was high at the edge where the core left the active state. Changes of `mwaitReq[c]` while the core is idle are ignored. A wake clears this arming.
- R9: `minFreqReq` rises one cycle after `pkgState` becomes 2, and `vReduceReq` rises one cycle after that. Both fall one cycle after `pkgState` leaves 2.
- R10: While `rstN` is low, every core and the package read 0 and both request flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| promoteEn | input | 1 | Enables promotion to extended halt |
| thrReq | input | 12 | Per-thread requested state codes |
| irq | input | 2 | Per-core interrupt wake |
| monHit | input | 2 | Per-core monitored-address access |
| mwaitReq | input | 2 | Per-core flag: current idle request is a monitor/wait entry |
| coreState | output | 6 | Resolved per-core states |
| pkgState | output | 3 | Resolved package state |
| minFreqReq | output | 1 | Request for lowest core frequency |
| vReduceReq | output | 1 | Request for voltage reduction |

## Verification
The hardest situation to reach is a monitored-address wake, because it depends on a single-cycle sample of `mwaitReq` taken at the edge where the core leaves active. The stimulus first parks the core in the active state with `mwaitReq` high, then requests an idle state so that the arming is taken. It then drops `mwaitReq` while the core is idle and pulses `monHit`, which must wake the core. After the core falls back to idle, a second pulse must now be ignored, because the wake cleared the arming and the re-entry sampled `mwaitReq` low. The resolution rules are swept over every combination of thread requests with promotion both on and off.

// File: rtl/idle_coord_pkg.sv
package idle_coord_pkg;

  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_C0  = 3'd0,
    ST_C1  = 3'd1,
    ST_C1E = 3'd2,
    ST_C3  = 3'd3,
    ST_C6  = 3'd4
  } idle_state_e;

  // strobes from control to datapath, one per core
  typedef struct packed {
    logic wake;     // force this core active at the next edge
    logic foldExt;  // fold extended-halt requests into light halt
  } core_strobe_t;

  // out-of-range request codes are clamped to the deepest state
  function automatic idle_state_e sanitize(input logic [STATE_W-1:0] code);
    return (code > 3'd4) ? ST_C6 : idle_state_e'(code);
  endfunction

endpackage

// File: rtl/idle_coord_datapath.sv
module idle_coord_datapath
  import idle_coord_pkg::*;
#(
  parameter int unsigned NUM_CORES        = 2,
  parameter int unsigned THREADS_PER_CORE = 2
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  logic [NUM_CORES*THREADS_PER_CORE*STATE_W-1:0] thrReq,
  input  core_strobe_t [NUM_CORES-1:0]               strobes,
  output logic [NUM_CORES*STATE_W-1:0]               coreState,
  output logic [STATE_W-1:0]                         pkgState
);

  localparam int unsigned CORE_REQ_W = THREADS_PER_CORE * STATE_W;

  function automatic idle_state_e coreMin(input logic [CORE_REQ_W-1:0] reqs,
                                          input logic fold);
    idle_state_e m;
    idle_state_e s;
    m = ST_C6;
    for (int t = 0; t < THREADS_PER_CORE; t++) begin
      s = sanitize(reqs[t*STATE_W +: STATE_W]);
      if (fold && s == ST_C1E) s = ST_C1;
      if (s < m) m = s;
    end
    return m;
  endfunction

  idle_state_e             rawCore [NUM_CORES];
  idle_state_e             repCore [NUM_CORES];
  idle_state_e             coreQ   [NUM_CORES];
  idle_state_e             pkgNext;
  idle_state_e             pkgQ;
  logic [NUM_CORES-1:0]    idleVec;
  logic                    allIdle;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_comb begin
      if (strobes[c].wake) rawCore[c] = ST_C0;
      else rawCore[c] = coreMin(thrReq[c*CORE_REQ_W +: CORE_REQ_W], strobes[c].foldExt);
    end

    assign idleVec[c] = (rawCore[c] != ST_C0);

    always_comb begin
      if (rawCore[c] == ST_C1 || rawCore[c] == ST_C1E)
        repCore[c] = (!strobes[c].foldExt && allIdle) ? ST_C1E : ST_C1;
      else
        repCore[c] = rawCore[c];
    end

    always_ff @(posedge clk) begin
      if (!rstN) coreQ[c] <= ST_C0;
      else       coreQ[c] <= repCore[c];
    end

    assign coreState[c*STATE_W +: STATE_W] = coreQ[c];
  end

  assign allIdle = &idleVec;

  always_comb begin
    pkgNext = ST_C6;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (repCore[c] < pkgNext) pkgNext = repCore[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pkgQ <= ST_C0;
    else       pkgQ <= pkgNext;
  end

  assign pkgState = pkgQ;

endmodule

// File: rtl/idle_coord_ctrl.sv
module idle_coord_ctrl
  import idle_coord_pkg::*;
#(
  parameter int unsigned NUM_CORES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         promoteEn,
  input  logic [NUM_CORES-1:0]         irq,
  input  logic [NUM_CORES-1:0]         monHit,
  input  logic [NUM_CORES-1:0]         mwaitReq,
  input  logic [NUM_CORES*STATE_W-1:0] coreState,
  input  logic [STATE_W-1:0]           pkgState,
  output core_strobe_t [NUM_CORES-1:0] strobes,
  output logic                         minFreqReq,
  output logic                         vReduceReq
);

  logic [NUM_CORES-1:0] armed;
  logic [NUM_CORES-1:0] wake;
  logic                 pkgExt;

  assign wake   = irq | (monHit & armed);
  assign pkgExt = (pkgState == ST_C1E);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic coreActive;
    assign coreActive = (coreState[c*STATE_W +: STATE_W] == ST_C0);

    assign strobes[c].wake    = wake[c];
    assign strobes[c].foldExt = !promoteEn;

    // arming is sampled while the core is still active, i.e. at entry
    always_ff @(posedge clk) begin
      if (!rstN)           armed[c] <= 1'b0;
      else if (wake[c])    armed[c] <= 1'b0;
      else if (coreActive) armed[c] <= mwaitReq[c];
    end
  end

  // frequency request first, voltage one cycle later; both drop together
  always_ff @(posedge clk) begin
    if (!rstN) begin
      minFreqReq <= 1'b0;
      vReduceReq <= 1'b0;
    end else begin
      minFreqReq <= pkgExt;
      vReduceReq <= pkgExt && minFreqReq;
    end
  end

endmodule

// File: rtl/idle_resolver.sv
module idle_resolver
  import idle_coord_pkg::*;
#(
  parameter int unsigned NUM_CORES        = 2,
  parameter int unsigned THREADS_PER_CORE = 2
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  logic                                          promoteEn,
  input  logic [NUM_CORES*THREADS_PER_CORE*STATE_W-1:0] thrReq,
  input  logic [NUM_CORES-1:0]                          irq,
  input  logic [NUM_CORES-1:0]                          monHit,
  input  logic [NUM_CORES-1:0]                          mwaitReq,
  output logic [NUM_CORES*STATE_W-1:0]                  coreState,
  output logic [STATE_W-1:0]                            pkgState,
  output logic                                          minFreqReq,
  output logic                                          vReduceReq
);

  core_strobe_t [NUM_CORES-1:0] strobes;

  idle_coord_ctrl #(.NUM_CORES(NUM_CORES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .promoteEn  (promoteEn),
    .irq        (irq),
    .monHit     (monHit),
    .mwaitReq   (mwaitReq),
    .coreState  (coreState),
    .pkgState   (pkgState),
    .strobes    (strobes),
    .minFreqReq (minFreqReq),
    .vReduceReq (vReduceReq)
  );

  idle_coord_datapath #(
    .NUM_CORES        (NUM_CORES),
    .THREADS_PER_CORE (THREADS_PER_CORE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .thrReq    (thrReq),
    .strobes   (strobes),
    .coreState (coreState),
    .pkgState  (pkgState)
  );

endmodule

// File: rtl/idle_resolver_chk.sv
module idle_resolver_chk #(
  parameter int unsigned NUM_CORES        = 2,
  parameter int unsigned THREADS_PER_CORE = 2
) (
  input logic                                    clk,
  input logic                                    rstN,
  input logic                                    promoteEn,
  input logic [NUM_CORES*THREADS_PER_CORE*3-1:0] thrReq,
  input logic [NUM_CORES-1:0]                    irq,
  input logic [NUM_CORES*3-1:0]                  coreState,
  input logic [2:0]                              pkgState,
  input logic                                    minFreqReq,
  input logic                                    vReduceReq
);

  logic [NUM_CORES-1:0] anyActive;
  logic [NUM_CORES-1:0] coreIsC0;

  always_comb begin
    anyActive = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      for (int t = 0; t < THREADS_PER_CORE; t++) begin
        if (thrReq[(c*THREADS_PER_CORE+t)*3 +: 3] == 3'd0) anyActive[c] = 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign coreIsC0[c] = (coreState[c*3 +: 3] == 3'd0);

    a_r2_active_thread: assert property (@(posedge clk) disable iff (!rstN)
      anyActive[c] |=> coreState[c*3 +: 3] == 3'd0)
      else $error("R2 core %0d not active", c);

    a_r7_irq_wake: assert property (@(posedge clk) disable iff (!rstN)
      irq[c] |=> coreState[c*3 +: 3] == 3'd0)
      else $error("R7 core %0d ignored interrupt", c);

    a_r4_no_ext_core: assert property (@(posedge clk) disable iff (!rstN)
      !promoteEn |=> coreState[c*3 +: 3] != 3'd2)
      else $error("R4 core %0d reported extended halt", c);

    a_r1_core_range: assert property (@(posedge clk) disable iff (!rstN)
      coreState[c*3 +: 3] <= 3'd4)
      else $error("R1 core %0d code out of range", c);
  end

  a_r3_pkg_active: assert property (@(posedge clk) disable iff (!rstN)
    (|coreIsC0) |-> pkgState == 3'd0)
    else $error("R3 package idle with an active core");

  a_r4_no_ext_pkg: assert property (@(posedge clk) disable iff (!rstN)
    !promoteEn |=> pkgState != 3'd2)
    else $error("R4 package reported extended halt");

  a_r5_ext_all_idle: assert property (@(posedge clk) disable iff (!rstN)
    pkgState == 3'd2 |-> !(|coreIsC0))
    else $error("R5 extended halt with an active core");

  a_r9_freq_after_ext: assert property (@(posedge clk) disable iff (!rstN)
    $rose(minFreqReq) |-> $past(pkgState) == 3'd2)
    else $error("R9 frequency request without extended halt");

  a_r9_volt_after_freq: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vReduceReq) |-> minFreqReq && $past(minFreqReq))
    else $error("R9 voltage request before frequency request");

  a_r9_drop_together: assert property (@(posedge clk) disable iff (!rstN)
    $fell(minFreqReq) |-> !vReduceReq)
    else $error("R9 voltage request outlived frequency request");

endmodule

bind idle_resolver idle_resolver_chk #(
  .NUM_CORES        (NUM_CORES),
  .THREADS_PER_CORE (THREADS_PER_CORE)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .promoteEn  (promoteEn),
  .thrReq     (thrReq),
  .irq        (irq),
  .coreState  (coreState),
  .pkgState   (pkgState),
  .minFreqReq (minFreqReq),
  .vReduceReq (vReduceReq)
);

// File: tb/idle_resolver_tb.sv
module idle_resolver_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        promoteEn;
  logic [11:0] thrReq;
  logic [1:0]  irq;
  logic [1:0]  monHit;
  logic [1:0]  mwaitReq;
  logic [5:0]  coreState;
  logic [2:0]  pkgState;
  logic        minFreqReq;
  logic        vReduceReq;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  idle_resolver u_dut (
    .clk(clk), .rstN(rstN), .promoteEn(promoteEn), .thrReq(thrReq),
    .irq(irq), .monHit(monHit), .mwaitReq(mwaitReq), .coreState(coreState),
    .pkgState(pkgState), .minFreqReq(minFreqReq), .vReduceReq(vReduceReq)
  );

  // {en, t0, t1, t2, t3, core0, core1, pkg}, 3 bits each
  localparam int NVEC = 13;
  localparam logic [23:0] VEC [NVEC] = '{
    {3'd0, 3'd1, 3'd3, 3'd3, 3'd4, 3'd1, 3'd3, 3'd1},
    {3'd1, 3'd1, 3'd3, 3'd3, 3'd4, 3'd2, 3'd3, 3'd2},
    {3'd1, 3'd2, 3'd3, 3'd0, 3'd4, 3'd1, 3'd0, 3'd0},
    {3'd0, 3'd2, 3'd2, 3'd4, 3'd4, 3'd1, 3'd4, 3'd1},
    {3'd1, 3'd4, 3'd4, 3'd4, 3'd3, 3'd4, 3'd3, 3'd3},
    {3'd1, 3'd0, 3'd4, 3'd4, 3'd4, 3'd0, 3'd4, 3'd0},
    {3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd2, 3'd2, 3'd2},
    {3'd0, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1},
    {3'd1, 3'd2, 3'd4, 3'd3, 3'd3, 3'd2, 3'd3, 3'd2},
    {3'd1, 3'd4, 3'd1, 3'd0, 3'd0, 3'd1, 3'd0, 3'd0},
    {3'd0, 3'd3, 3'd4, 3'd4, 3'd3, 3'd3, 3'd3, 3'd3},
    {3'd1, 3'd3, 3'd0, 3'd1, 3'd2, 3'd0, 3'd1, 3'd0},
    {3'd0, 3'd7, 3'd7, 3'd7, 3'd7, 3'd4, 3'd4, 3'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setReq(input int a, input int b, input int c, input int d);
    thrReq = {d[2:0], c[2:0], b[2:0], a[2:0]};
  endtask

  // expected resolution, written from the requirements
  task automatic refResolve(input int en, input int t[4],
                            output int c0, output int c1, output int p);
    int core[2];
    int rep[2];
    bit allIdle;
    for (int c = 0; c < 2; c++) begin
      core[c] = 4;
      for (int k = 0; k < 2; k++) begin
        int v;
        v = (t[2*c+k] > 4) ? 4 : t[2*c+k];
        if (en == 0 && v == 2) v = 1;
        if (v < core[c]) core[c] = v;
      end
    end
    allIdle = (core[0] != 0) && (core[1] != 0);
    for (int c = 0; c < 2; c++) begin
      if (core[c] == 1 || core[c] == 2) rep[c] = (en != 0 && allIdle) ? 2 : 1;
      else rep[c] = core[c];
    end
    c0 = rep[0];
    c1 = rep[1];
    p  = (rep[0] < rep[1]) ? rep[0] : rep[1];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; promoteEn = 1'b1; irq = '0; monHit = '0; mwaitReq = '0;
    setReq(4, 4, 4, 4);
    repeat (3) tick();
    // R10 reset state
    chk("R10 core0", coreState[2:0], 0);
    chk("R10 core1", coreState[5:3], 0);
    chk("R10 pkg", pkgState, 0);
    chk("R10 minFreq", minFreqReq, 0);
    chk("R10 vReduce", vReduceReq, 0);
    rstN = 1'b1;
    tick();

    // table of directed vectors: R1 R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      promoteEn = VEC[i][21];
      thrReq = {VEC[i][11:9], VEC[i][14:12], VEC[i][17:15], VEC[i][20:18]};
      tick();
      chk($sformatf("R2 vec%0d core0", i), coreState[2:0], VEC[i][8:6]);
      chk($sformatf("R5 vec%0d core1", i), coreState[5:3], VEC[i][5:3]);
      chk($sformatf("R3 vec%0d pkg", i), pkgState, VEC[i][2:0]);
    end

    // exhaustive sweep against the reference: R2 R3 R4 R5
    for (int en = 0; en < 2; en++)
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 5; b++)
          for (int c = 0; c < 5; c++)
            for (int d = 0; d < 5; d++) begin
              int t[4];
              int e0, e1, ep;
              t = '{a, b, c, d};
              refResolve(en, t, e0, e1, ep);
              promoteEn = en[0];
              setReq(a, b, c, d);
              tick();
              chk("R2 sweep core0", coreState[2:0], e0);
              chk("R4 sweep core1", coreState[5:3], e1);
              chk("R3 sweep pkg", pkgState, ep);
            end

    // R6 registered latency
    promoteEn = 1'b0;
    setReq(3, 3, 3, 3);
    tick();
    setReq(4, 4, 4, 4);
    #2;
    chk("R6 before edge", coreState[2:0], 3);
    tick();
    chk("R6 after edge", coreState[2:0], 4);

    // R8 armed monitor wake
    setReq(0, 0, 0, 0);
    mwaitReq = 2'b10;
    tick();
    setReq(3, 3, 3, 3);
    tick();
    chk("R8 entered", coreState[5:3], 3);
    mwaitReq = 2'b00;
    tick();
    monHit = 2'b10;
    tick();
    chk("R8 armed wake core1", coreState[5:3], 0);
    chk("R8 core0 untouched", coreState[2:0], 3);
    monHit = 2'b00;
    tick();
    chk("R8 back idle", coreState[5:3], 3);
    monHit = 2'b10;
    tick();
    chk("R8 unarmed hit ignored", coreState[5:3], 3);
    monHit = 2'b00;

    // R7 interrupt wake and return
    irq = 2'b01;
    tick();
    chk("R7 irq core0", coreState[2:0], 0);
    chk("R7 irq core1", coreState[5:3], 3);
    chk("R7 irq pkg", pkgState, 0);
    irq = 2'b00;
    tick();
    chk("R7 return core0", coreState[2:0], 3);

    // R9 flags off with promotion disabled
    setReq(1, 1, 1, 1);
    repeat (3) tick();
    chk("R9 no ext pkg", pkgState, 1);
    chk("R9 no minFreq", minFreqReq, 0);

    // R9 flag ordering
    setReq(0, 0, 0, 0);
    tick();
    promoteEn = 1'b1;
    setReq(1, 1, 1, 1);
    tick();
    chk("R9 pkg ext", pkgState, 2);
    chk("R9 minFreq low at entry", minFreqReq, 0);
    tick();
    chk("R9 minFreq rises", minFreqReq, 1);
    chk("R9 vReduce waits", vReduceReq, 0);
    tick();
    chk("R9 vReduce rises", vReduceReq, 1);
    setReq(0, 0, 0, 0);
    tick();
    chk("R9 pkg left", pkgState, 0);
    chk("R9 minFreq held", minFreqReq, 1);
    chk("R9 vReduce held", vReduceReq, 1);
    tick();
    chk("R9 minFreq falls", minFreqReq, 0);
    chk("R9 vReduce falls", vReduceReq, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule